// File: doc/BRIEF.md
# Microcode Sequencer with Global Stall

This block steps a microcoded geometry engine through its program. Each cycle it chooses the next 15-bit code-RAM address from one of three sources: the sequential successor, an unconditional target, or a target taken only when a condition input is set. Alongside the program counter it holds two microcode-loaded pointers. The first is a 14-bit data-memory pointer into a store of 32-bit words. The second points at raster-engine registers.

A single stall input freezes the program counter and both pointers together. While the engine is stalled, a host single-word transfer may overwrite the program counter. The register pointer has no host path at all. Instruction decoding happens upstream, so the block receives an already decoded next-address selector, a condition bit, a jump target and load strobes.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the data pointer and the register pointer to 0.
- R2: With selector 2'b00 and no stall, the program counter advances by one per cycle, and 0x7FFF wraps to 0x0000.
- R3: With selector 2'b01 and no stall, the program counter takes the jump target on the next cycle.
- R4: With selector 2'b10 and no stall, the program counter takes the jump target when the condition input is 1 and advances by one when it is 0.
- R5: Selector code 2'b11 is reserved and advances the program counter by one, whatever the condition input is.
- R6: When not stalled, a data-pointer load strobe sets the data pointer to the supplied 14-bit value on the next cycle; without the strobe the pointer holds.
- R7: When not stalled, a register-pointer load strobe sets the register pointer on the next cycle; without the strobe it holds, and a host program-counter write never changes it.
- R8: While stall is 1, the program counter, the data pointer and the register pointer keep their values, whatever the selector and the pointer load strobes are. The one exception to this is R9.
- R9: While stall is 1, a host program-counter write sets the program counter to the host value on the next cycle.
- R10: A host program-counter write while stall is 0 is ignored, and the program counter follows the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Global freeze of all sequencer state |
| nxt_sel_i | input | 2 | Next-address selector: 00 sequential, 01 jump, 10 conditional jump, 11 reserved (sequential) |
| cond_i | input | 1 | Condition for the conditional jump |
| jmp_addr_i | input | PC_W (15) | Jump target |
| dp_load_i | input | 1 | Data-pointer load strobe from microcode |
| dp_val_i | input | DP_W (14) | Data-pointer load value |
| rp_load_i | input | 1 | Register-pointer load strobe from microcode |
| rp_val_i | input | RP_W (8) | Register-pointer load value |
| host_pc_we_i | input | 1 | Host program-counter write strobe |
| host_pc_i | input | PC_W (15) | Host program-counter value |
| pc_o | output | PC_W (15) | Program counter to the code RAM |
| dp_o | output | DP_W (14) | Data-memory pointer |
| rp_o | output | RP_W (8) | Raster-register pointer |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge and that the selector is one of its four codes. The freeze and load properties compare each register against its own value one cycle earlier. They therefore also assume that the clock runs without gaps whenever reset is low. The stimulus changes inputs only one time unit after a rising edge and never leaves an input undriven. It also covers reserved selector code 2'b11 and the host write both inside and outside a stall, so every branch of these properties is reached.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int unsigned PC_W_DEF = 15;
    localparam int unsigned DP_W_DEF = 14;
    localparam int unsigned RP_W_DEF = 8;

    typedef enum logic [1:0] {
        NXT_SEQ   = 2'b00,
        NXT_JUMP  = 2'b01,
        NXT_CJUMP = 2'b10,
        NXT_RSVD  = 2'b11
    } nxt_sel_e;

    // Decide whether the jump target replaces the sequential successor.
    function automatic logic branch_taken(input nxt_sel_e sel, input logic cond);
        case (sel)
            NXT_JUMP:  return 1'b1;
            NXT_CJUMP: return cond;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/useq_pc_unit.sv
module useq_pc_unit
    import useq_pkg::*;
#(
    parameter int unsigned PC_W = PC_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_i,
    input  nxt_sel_e        sel_i,
    input  logic            cond_i,
    input  logic [PC_W-1:0] jmp_addr_i,
    input  logic            host_we_i,
    input  logic [PC_W-1:0] host_pc_i,
    output logic [PC_W-1:0] pc_o
);

    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_seq;
    logic [PC_W-1:0] pc_d;
    logic            take;

    assign pc_seq = pc_q + PC_ONE;
    assign take   = branch_taken(sel_i, cond_i);

    always_comb begin
        if (stall_i) begin
            pc_d = host_we_i ? host_pc_i : pc_q;
        end else begin
            pc_d = take ? jmp_addr_i : pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_o = pc_q;

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !host_we_i) |=> $stable(pc_o));

    assert_host_load_R9: assert property (@(posedge clk) disable iff (rst)
        (stall_i && host_we_i) |=> (pc_o == $past(host_pc_i)));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && (sel_i == NXT_SEQ || sel_i == NXT_RSVD)) |=> (pc_o == $past(pc_o) + PC_ONE));

    assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && sel_i == NXT_JUMP) |=> (pc_o == $past(jmp_addr_i)));

    assert_cjump_R4: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && sel_i == NXT_CJUMP && cond_i) |=> (pc_o == $past(jmp_addr_i)));

endmodule

// File: rtl/useq_ptr_reg.sv
module useq_ptr_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stall_i,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] ptr_o
);

    logic [W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)                    ptr_q <= '0;
        else if (load_i && !stall_i) ptr_q <= val_i;
    end

    assign ptr_o = ptr_q;

    assert_ptr_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(ptr_o));

    // Covers R6 and R7: without a strobe the pointer holds.
    assert_ptr_hold_R6_R7: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(ptr_o));

    assert_ptr_load_R6: assert property (@(posedge clk) disable iff (rst)
        (load_i && !stall_i) |=> (ptr_o == $past(val_i)));

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int unsigned PC_W = PC_W_DEF,
    parameter int unsigned DP_W = DP_W_DEF,
    parameter int unsigned RP_W = RP_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_i,
    input  logic [1:0]      nxt_sel_i,
    input  logic            cond_i,
    input  logic [PC_W-1:0] jmp_addr_i,
    input  logic            dp_load_i,
    input  logic [DP_W-1:0] dp_val_i,
    input  logic            rp_load_i,
    input  logic [RP_W-1:0] rp_val_i,
    input  logic            host_pc_we_i,
    input  logic [PC_W-1:0] host_pc_i,
    output logic [PC_W-1:0] pc_o,
    output logic [DP_W-1:0] dp_o,
    output logic [RP_W-1:0] rp_o
);

    nxt_sel_e sel;
    assign sel = nxt_sel_e'(nxt_sel_i);

    useq_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .stall_i    (stall_i),
        .sel_i      (sel),
        .cond_i     (cond_i),
        .jmp_addr_i (jmp_addr_i),
        .host_we_i  (host_pc_we_i),
        .host_pc_i  (host_pc_i),
        .pc_o       (pc_o)
    );

    useq_ptr_reg #(.W(DP_W)) u_dptr (
        .clk     (clk),
        .rst     (rst),
        .stall_i (stall_i),
        .load_i  (dp_load_i),
        .val_i   (dp_val_i),
        .ptr_o   (dp_o)
    );

    // The register pointer is wired to microcode strobes only; no host path.
    useq_ptr_reg #(.W(RP_W)) u_rptr (
        .clk     (clk),
        .rst     (rst),
        .stall_i (stall_i),
        .load_i  (rp_load_i),
        .val_i   (rp_val_i),
        .ptr_o   (rp_o)
    );

    assert_rp_host_isolated_R7: assert property (@(posedge clk) disable iff (rst)
        (host_pc_we_i && !rp_load_i) |=> $stable(rp_o));

    assert_host_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && host_pc_we_i && nxt_sel_i == 2'b01) |=> (pc_o == $past(jmp_addr_i)));

endmodule

// File: tb/useq_sequencer_tb_top.sv
module useq_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    typedef struct packed {
        logic        stall;
        logic [1:0]  sel;
        logic        cond;
        logic [14:0] jaddr;
        logic        dpl;
        logic [13:0] dpv;
        logic        rpl;
        logic [7:0]  rpv;
        logic        hwe;
        logic [14:0] hpc;
        logic [14:0] exp_pc;
        logic [13:0] exp_dp;
        logic [7:0]  exp_rp;
    } vec_t;

    // stall sel cond jaddr dpl dpv rpl rpv hwe hpc | exp pc dp rp
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b00, 1'b0, 15'h0000, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b0, 15'h0000, 15'h0001, 14'h0000, 8'h00}, // R2 step
        '{1'b0, 2'b01, 1'b0, 15'h1234, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b0, 15'h0000, 15'h1234, 14'h0000, 8'h00}, // R3 jump
        '{1'b0, 2'b10, 1'b0, 15'h0040, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b0, 15'h0000, 15'h1235, 14'h0000, 8'h00}, // R4 not taken
        '{1'b0, 2'b10, 1'b1, 15'h0040, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b0, 15'h0000, 15'h0040, 14'h0000, 8'h00}, // R4 taken
        '{1'b0, 2'b11, 1'b1, 15'h7000, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b0, 15'h0000, 15'h0041, 14'h0000, 8'h00}, // R5 reserved
        '{1'b0, 2'b00, 1'b0, 15'h0000, 1'b1, 14'h2ABC, 1'b1, 8'h5A, 1'b0, 15'h0000, 15'h0042, 14'h2ABC, 8'h5A}, // R6 R7 loads
        '{1'b1, 2'b01, 1'b1, 15'h1111, 1'b1, 14'h0001, 1'b1, 8'h01, 1'b0, 15'h0000, 15'h0042, 14'h2ABC, 8'h5A}, // R8 freeze
        '{1'b1, 2'b00, 1'b0, 15'h0000, 1'b0, 14'h0000, 1'b1, 8'h33, 1'b1, 15'h7FFF, 15'h7FFF, 14'h2ABC, 8'h5A}, // R9 host load, R7
        '{1'b0, 2'b00, 1'b0, 15'h0000, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b0, 15'h0000, 15'h0000, 14'h2ABC, 8'h5A}, // R2 wrap, R6 hold
        '{1'b0, 2'b00, 1'b0, 15'h0000, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b1, 15'h0500, 15'h0001, 14'h2ABC, 8'h5A}, // R10 ignored, R7
        '{1'b0, 2'b01, 1'b0, 15'h7FFE, 1'b0, 14'h0000, 1'b1, 8'hC3, 1'b0, 15'h0000, 15'h7FFE, 14'h2ABC, 8'hC3}, // R3 R7
        '{1'b0, 2'b00, 1'b0, 15'h0000, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b0, 15'h0000, 15'h7FFF, 14'h2ABC, 8'hC3}, // R2
        '{1'b0, 2'b10, 1'b0, 15'h0123, 1'b0, 14'h0000, 1'b0, 8'h00, 1'b0, 15'h0000, 15'h0000, 14'h2ABC, 8'hC3}  // R4 wrap
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall_i = 1'b0;
    logic [1:0]  nxt_sel_i = 2'b00;
    logic        cond_i = 1'b0;
    logic [14:0] jmp_addr_i = '0;
    logic        dp_load_i = 1'b0;
    logic [13:0] dp_val_i = '0;
    logic        rp_load_i = 1'b0;
    logic [7:0]  rp_val_i = '0;
    logic        host_pc_we_i = 1'b0;
    logic [14:0] host_pc_i = '0;
    logic [14:0] pc_o;
    logic [13:0] dp_o;
    logic [7:0]  rp_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    useq_sequencer dut_i (
        .clk          (clk),
        .rst          (rst),
        .stall_i      (stall_i),
        .nxt_sel_i    (nxt_sel_i),
        .cond_i       (cond_i),
        .jmp_addr_i   (jmp_addr_i),
        .dp_load_i    (dp_load_i),
        .dp_val_i     (dp_val_i),
        .rp_load_i    (rp_load_i),
        .rp_val_i     (rp_val_i),
        .host_pc_we_i (host_pc_we_i),
        .host_pc_i    (host_pc_i),
        .pc_o         (pc_o),
        .dp_o         (dp_o),
        .rp_o         (rp_o)
    );

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        stall_i      = v.stall;
        nxt_sel_i    = v.sel;
        cond_i       = v.cond;
        jmp_addr_i   = v.jaddr;
        dp_load_i    = v.dpl;
        dp_val_i     = v.dpv;
        rp_load_i    = v.rpl;
        rp_val_i     = v.rpv;
        host_pc_we_i = v.hwe;
        host_pc_i    = v.hpc;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1 pc after reset", 32'(pc_o), 32'h0);
        check("R1 dp after reset", 32'(dp_o), 32'h0);
        check("R1 rp after reset", 32'(rp_o), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            @(posedge clk);
            #1;
            check($sformatf("vector %0d pc (see table tag)", i), 32'(pc_o), 32'(VECS[i].exp_pc));
            check($sformatf("vector %0d dp (see table tag)", i), 32'(dp_o), 32'(VECS[i].exp_dp));
            check($sformatf("vector %0d rp (see table tag)", i), 32'(rp_o), 32'(VECS[i].exp_rp));
        end

        // R9: two host writes in a row during a stall, the later one wins
        drive('{1'b1, 2'b01, 1'b1, 15'h0AAA, 1'b0, 14'h0, 1'b0, 8'h0, 1'b1, 15'h0123, 15'h0, 14'h0, 8'h0});
        @(posedge clk);
        #1;
        check("R9 host write 1", 32'(pc_o), 32'h0123);
        host_pc_i = 15'h4321;
        @(posedge clk);
        #1;
        check("R9 host write 2", 32'(pc_o), 32'h4321);

        // R8: a long stall keeps everything frozen
        host_pc_we_i = 1'b0;
        dp_load_i = 1'b1;
        dp_val_i = 14'h3FFF;
        repeat (3) @(posedge clk);
        #1;
        check("R8 pc long stall", 32'(pc_o), 32'h4321);
        check("R8 dp long stall", 32'(dp_o), 32'h2ABC);

        // R6: a load after the stall releases takes the full-width value
        stall_i = 1'b0;
        nxt_sel_i = 2'b00;
        @(posedge clk);
        #1;
        check("R6 dp load all ones", 32'(dp_o), 32'h3FFF);
        check("R2 step after release", 32'(pc_o), 32'h4322);

        // R1: a reset in mid-run clears all state even with loads pending
        rst = 1'b1;
        rp_load_i = 1'b1;
        rp_val_i = 8'hEE;
        @(posedge clk);
        #1;
        check("R1 pc mid-run reset", 32'(pc_o), 32'h0);
        check("R1 dp mid-run reset", 32'(dp_o), 32'h0);
        check("R1 rp mid-run reset", 32'(rp_o), 32'h0);
        rst = 1'b0;
        dp_load_i = 1'b0;
        rp_load_i = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule